// File: doc/BRIEF.md
# Rename Stage Control State Machine

This block is the control core of one thread's register-rename stage. It does no register mapping itself. Each cycle it decides whether the stage can pass one instruction downstream, whether it must hold back, and where the next instruction comes from. The next instruction is taken either from the decode input or from a small skid buffer that soaks up instructions decode sent while the stage was stopped. It raises one-cycle block and unblock pulses toward decode. It also reports its state and the source of every instruction it issues.

Three kinds of disturbance reach it. A squash from commit carries a sequence number. A stall comes either from the downstream stage or from a resource-full flag. An instruction may need serialization. For serialization, commit reports whether the reorder buffer is empty and the stage knows how many instructions are still in flight. A serializing instruction is parked in a single hold slot until both show the machine is drained. It is then placed at the head of the skid buffer so it issues before anything that queued behind it. On a squash, the parked instruction survives only if it is not younger than the squash point.

Top module: `rn_ctl_fsm`

## Requirements
- R1: After reset the state is Idle (code 0), no instruction is issued, both decode pulses are low and the skid error flag is clear. State codes: Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4, SerializeStall 5.
- R2: In Idle or Running with no squash and no stall, a valid input is issued the next cycle with its sequence number and kind unchanged and the skid-source flag low, and the state becomes Running. Kind codes: 0 plain, 1 serialize-before, 2 serialize-after.
- R3: A stall (downstream stall or resource-full) in Idle, Running or Unblocking moves to Blocked, stores the current input in the skid buffer and pulses block once. Further stall cycles in Blocked keep storing inputs and give no new block pulse.
- R4: Blocked with no stall goes to Unblocking. Unblocking issues skid entries one per cycle in arrival order with the skid-source flag high. Once the buffer is empty and no input is present, it returns to Running with an unblock pulse.
- R5: A squash has top priority over stall and all other transitions: the next state is Squashing, the skid buffer is emptied, the input of that cycle is discarded, and nothing is issued while Squashing.
- R6: A squash arriving in Blocked or Unblocking pulses unblock and discards any parked instruction.
- R7: A squash in SerializeStall keeps the parked instruction, with no unblock pulse, when its sequence number is less than or equal to the squash sequence number, and Squashing then leads back to SerializeStall. Otherwise the instruction is discarded, unblock pulses and Squashing leads to Running.
- R8: Squashing leaves only on a cycle without stall. It goes to SerializeStall if serialization resumes, else to Unblocking if a stall was seen during Squashing (block pulses on the first such stall only), else to Running.
- R9: A serialize-before instruction met while the reorder buffer is not empty or the in-flight count is nonzero is parked. The state becomes SerializeStall, with a block pulse when it came from the decode input. The state stays there while not drained or while stalled. On leaving, the state becomes Unblocking and the parked instruction is issued first, with kind 1, ahead of inputs that queued meanwhile.
- R10: After a serialize-after instruction issues, the next instruction is handled as serialize-before if the machine is not drained at that time, and it is then issued with kind 1. If the machine is drained, the pending mark is dropped and the instruction issues with its own kind.
- R11: The skid buffer holds up to SKID_DEPTH entries without raising the error flag. A push into a full buffer sets a sticky error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Instruction present from decode |
| in_seq | input | SEQ_W | Sequence number of the input instruction |
| in_kind | input | 2 | Serialization kind of the input |
| squash_vld | input | 1 | Squash request from commit |
| squash_seq | input | SEQ_W | Youngest surviving sequence number of the squash |
| stall_req | input | 1 | Stall request from the downstream stage |
| res_full | input | 1 | A downstream resource has no free entry |
| rob_empty | input | 1 | Reorder buffer reported empty |
| inflight | input | CNT_W | Instructions issued but not yet seen downstream |
| out_vld | output | 1 | Instruction issued this cycle |
| out_seq | output | SEQ_W | Sequence number of the issued instruction |
| out_kind | output | 2 | Kind of the issued instruction (1 when it was serialized) |
| out_skid | output | 1 | Issued instruction came from the skid buffer |
| blk_dec | output | 1 | One-cycle block pulse to decode |
| unblk_dec | output | 1 | One-cycle unblock pulse to decode |
| state_o | output | 3 | Current state code |
| skid_err | output | 1 | Sticky skid overflow flag |

## Verification
Every output is a register, so each result belongs to the inputs of exactly one cycle and appears on the rising edge that ends it. The bench changes inputs on the falling edge, waits for one rising edge, and reads state, issue and pulse outputs at the following falling edge. Multi-cycle behaviour such as draining the skid buffer or the serialize stall is checked as a sequence of single-edge steps. Each step names the exact cycle in which a given sequence number or pulse must show.

// File: rtl/rn_ctl_pkg.sv
package rn_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RUN      = 3'd1,
        ST_BLOCKED  = 3'd2,
        ST_UNBLOCK  = 3'd3,
        ST_SQUASH   = 3'd4,
        ST_SERSTALL = 3'd5
    } rn_state_e;

    typedef enum logic [1:0] {
        K_PLAIN      = 2'd0,
        K_SER_BEFORE = 2'd1,
        K_SER_AFTER  = 2'd2
    } rn_kind_e;

    localparam int KIND_W = 2;

    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned m);
        return (a + b) % m;
    endfunction

endpackage

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo
    import rn_ctl_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         pop,
    input  logic         push_front,
    input  logic [W-1:0] front_data,
    input  logic         push_back,
    input  logic [W-1:0] back_data,
    output logic [W-1:0] head_data,
    output logic         empty,
    output logic         ovf
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] head_q, head_m1, head_p1, tail;
    logic [CW-1:0] cnt_q, cnt_mid;
    logic          pf_ok, pb_ok;

    always_comb begin
        pf_ok   = push_front && (cnt_q < CW'(DEPTH));
        cnt_mid = cnt_q - CW'(pop) + CW'(pf_ok);
        pb_ok   = push_back && (cnt_mid < CW'(DEPTH));
        ovf     = (push_front && !pf_ok) || (push_back && !pb_ok);
        head_m1 = IW'(wrap_add(32'(head_q), 32'(DEPTH - 1), 32'(DEPTH)));
        head_p1 = IW'(wrap_add(32'(head_q), 32'd1, 32'(DEPTH)));
        tail    = IW'(wrap_add(32'(head_q), 32'(cnt_q), 32'(DEPTH)));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pf_ok)    head_q <= head_m1;
            else if (pop) head_q <= head_p1;
            cnt_q <= cnt_mid + CW'(pb_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && pf_ok) mem[head_m1] <= front_data;
        if (!flush && pb_ok) mem[tail]    <= back_data;
    end

    assign head_data = mem[head_q];
    assign empty     = (cnt_q == '0);
endmodule

// File: rtl/rn_ser_hold.sv
module rn_ser_hold #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEQ_W-1:0] load_seq,
    input  logic             clr,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             vld,
    output logic [SEQ_W-1:0] seq,
    output logic             keep
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            seq <= '0;
        end else if (load) begin
            vld <= 1'b1;
            seq <= load_seq;
        end else if (clr) begin
            vld <= 1'b0;
        end
    end

    assign keep = vld && (seq <= sq_seq);
endmodule

// File: rtl/rn_ctl_fsm.sv
module rn_ctl_fsm
    import rn_ctl_pkg::*;
#(
    parameter int SEQ_W      = 16,
    parameter int CNT_W      = 6,
    parameter int SKID_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic [1:0]       in_kind,
    input  logic             squash_vld,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             stall_req,
    input  logic             res_full,
    input  logic             rob_empty,
    input  logic [CNT_W-1:0] inflight,
    output logic             out_vld,
    output logic [SEQ_W-1:0] out_seq,
    output logic [1:0]       out_kind,
    output logic             out_skid,
    output logic             blk_dec,
    output logic             unblk_dec,
    output logic [2:0]       state_o,
    output logic             skid_err
);
    localparam int ENT_W = SEQ_W + KIND_W;

    rn_state_e        st_q, st_d;
    logic             drained, stall;
    logic             f_flush, f_pop, f_pf, f_pb, f_empty, f_ovf;
    logic [ENT_W-1:0] f_head, f_front, f_back;
    logic             h_load, h_clr, h_vld, h_keep;
    logic [SEQ_W-1:0] h_seq;
    logic             ser_next_q, ser_next_d, res_ser_q, res_ser_d, res_unb_q, res_unb_d;
    logic             blk_d, unblk_d, ov_d, oskid_d;
    logic [ENT_W-1:0] oent_d, oent_q;
    logic             go, go_skid, mark;
    logic [ENT_W-1:0] cand;
    rn_kind_e         cand_kind;

    assign drained = rob_empty && (inflight == '0);
    assign stall   = stall_req || res_full;
    assign f_front = {K_SER_BEFORE, h_seq};
    assign f_back  = {in_kind, in_seq};

    rn_skid_fifo #(.W(ENT_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk(clk), .rst(rst), .flush(f_flush), .pop(f_pop),
        .push_front(f_pf), .front_data(f_front),
        .push_back(f_pb), .back_data(f_back),
        .head_data(f_head), .empty(f_empty), .ovf(f_ovf)
    );

    rn_ser_hold #(.SEQ_W(SEQ_W)) u_hold (
        .clk(clk), .rst(rst), .load(h_load), .load_seq(cand[SEQ_W-1:0]),
        .clr(h_clr), .sq_seq(squash_seq),
        .vld(h_vld), .seq(h_seq), .keep(h_keep)
    );

    always_comb begin
        st_d       = st_q;
        blk_d      = 1'b0;
        unblk_d    = 1'b0;
        ov_d       = 1'b0;
        oskid_d    = 1'b0;
        oent_d     = '0;
        f_flush    = 1'b0;
        f_pop      = 1'b0;
        f_pf       = 1'b0;
        f_pb       = 1'b0;
        h_load     = 1'b0;
        h_clr      = 1'b0;
        ser_next_d = ser_next_q;
        res_ser_d  = res_ser_q;
        res_unb_d  = res_unb_q;
        go         = 1'b0;
        go_skid    = 1'b0;
        cand       = f_back;
        mark       = 1'b0;

        if (squash_vld) begin
            st_d       = ST_SQUASH;
            f_flush    = 1'b1;
            ser_next_d = 1'b0;
            res_unb_d  = 1'b0;
            case (st_q)
                ST_BLOCKED, ST_UNBLOCK: begin
                    unblk_d   = 1'b1;
                    h_clr     = 1'b1;
                    res_ser_d = 1'b0;
                end
                ST_SERSTALL, ST_SQUASH: begin
                    if (h_keep) begin
                        res_ser_d = 1'b1;
                    end else begin
                        h_clr     = 1'b1;
                        res_ser_d = 1'b0;
                        if (st_q == ST_SERSTALL) unblk_d = 1'b1;
                    end
                end
                default: begin
                    h_clr     = 1'b1;
                    res_ser_d = 1'b0;
                end
            endcase
        end else if (stall) begin
            case (st_q)
                ST_IDLE, ST_RUN, ST_UNBLOCK: begin
                    f_pb  = in_vld;
                    st_d  = ST_BLOCKED;
                    blk_d = 1'b1;
                end
                ST_SQUASH: begin
                    res_unb_d = 1'b1;
                    blk_d     = !res_unb_q;
                end
                default: f_pb = in_vld;
            endcase
        end else begin
            case (st_q)
                ST_BLOCKED: begin
                    f_pb = in_vld;
                    st_d = ST_UNBLOCK;
                end
                ST_SQUASH: begin
                    st_d      = res_ser_q ? ST_SERSTALL : (res_unb_q ? ST_UNBLOCK : ST_RUN);
                    res_ser_d = 1'b0;
                    res_unb_d = 1'b0;
                end
                ST_SERSTALL: begin
                    f_pb = in_vld;
                    if (drained) begin
                        f_pf  = 1'b1;
                        h_clr = 1'b1;
                        st_d  = ST_UNBLOCK;
                    end
                end
                ST_UNBLOCK: begin
                    if (f_empty && !in_vld) begin
                        st_d    = ST_RUN;
                        unblk_d = 1'b1;
                    end else begin
                        f_pb = in_vld;
                        if (!f_empty) begin
                            cand    = f_head;
                            go      = 1'b1;
                            go_skid = 1'b1;
                            f_pop   = 1'b1;
                        end
                    end
                end
                default: begin
                    if (in_vld) begin
                        go   = 1'b1;
                        st_d = ST_RUN;
                    end
                end
            endcase
        end

        cand_kind = rn_kind_e'(cand[ENT_W-1:SEQ_W]);
        if (go) begin
            mark = (cand_kind == K_SER_BEFORE) || ser_next_q;
            if (mark && !drained) begin
                h_load     = 1'b1;
                st_d       = ST_SERSTALL;
                ser_next_d = 1'b0;
                if (!go_skid) blk_d = 1'b1;
            end else begin
                ov_d       = 1'b1;
                oent_d     = cand;
                oskid_d    = go_skid;
                ser_next_d = (cand_kind == K_SER_AFTER);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            ser_next_q <= 1'b0;
            res_ser_q  <= 1'b0;
            res_unb_q  <= 1'b0;
            blk_dec    <= 1'b0;
            unblk_dec  <= 1'b0;
            out_vld    <= 1'b0;
            out_skid   <= 1'b0;
            oent_q     <= '0;
            skid_err   <= 1'b0;
        end else begin
            st_q       <= st_d;
            ser_next_q <= ser_next_d;
            res_ser_q  <= res_ser_d;
            res_unb_q  <= res_unb_d;
            blk_dec    <= blk_d;
            unblk_dec  <= unblk_d;
            out_vld    <= ov_d;
            out_skid   <= oskid_d;
            oent_q     <= oent_d;
            skid_err   <= skid_err || f_ovf;
        end
    end

    assign out_seq  = oent_q[SEQ_W-1:0];
    assign out_kind = oent_q[ENT_W-1:SEQ_W];
    assign state_o  = st_q;
endmodule

// File: rtl/rn_ctl_chk.sv
module rn_ctl_chk
    import rn_ctl_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             squash_vld,
    input logic             rob_empty,
    input logic [CNT_W-1:0] inflight,
    input logic [2:0]       state_o,
    input logic             blk_dec,
    input logic             unblk_dec,
    input logic             out_vld,
    input logic             out_skid,
    input logic             skid_err
);
    AST_SQUASH_ENTER: assert property (@(posedge clk) disable iff (rst)
        squash_vld |=> (state_o == ST_SQUASH)); // R5
    AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_SQUASH) |=> !out_vld); // R5
    AST_NO_REBLOCK: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_BLOCKED && !squash_vld) |=> !blk_dec); // R3
    AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_SERSTALL && !squash_vld && !(rob_empty && inflight == '0))
        |=> (state_o == ST_SERSTALL)); // R9
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(blk_dec && unblk_dec)); // R4
    AST_SKID_SRC: assert property (@(posedge clk) disable iff (rst)
        out_skid |-> out_vld); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !skid_err); // R11
endmodule

bind rn_ctl_fsm rn_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .squash_vld(squash_vld), .rob_empty(rob_empty),
    .inflight(inflight), .state_o(state_o), .blk_dec(blk_dec),
    .unblk_dec(unblk_dec), .out_vld(out_vld), .out_skid(out_skid),
    .skid_err(skid_err)
);

// File: tb/rn_ctl_fsm_test.sv
module rn_ctl_fsm_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] in_seq = '0;
    logic [1:0]  in_kind = '0;
    logic        squash_vld = 1'b0;
    logic [15:0] squash_seq = '0;
    logic        stall_req = 1'b0;
    logic        res_full = 1'b0;
    logic        rob_empty = 1'b1;
    logic [5:0]  inflight = '0;
    logic        out_vld, out_skid, blk_dec, unblk_dec, skid_err;
    logic [15:0] out_seq;
    logic [1:0]  out_kind;
    logic [2:0]  state_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    rn_ctl_fsm uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_seq(in_seq), .in_kind(in_kind),
        .squash_vld(squash_vld), .squash_seq(squash_seq), .stall_req(stall_req),
        .res_full(res_full), .rob_empty(rob_empty), .inflight(inflight),
        .out_vld(out_vld), .out_seq(out_seq), .out_kind(out_kind), .out_skid(out_skid),
        .blk_dec(blk_dec), .unblk_dec(unblk_dec), .state_o(state_o), .skid_err(skid_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        in_vld = 1'b0; in_kind = 2'd0; squash_vld = 1'b0;
        stall_req = 1'b0; res_full = 1'b0;
    endtask

    task automatic feed(input int seq, input int kind);
        in_vld = 1'b1; in_seq = 16'(seq); in_kind = 2'(kind);
    endtask

    task automatic t_reset();
        chk("R1 state", int'(state_o), 0);
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 pulses", int'({blk_dec, unblk_dec}), 0);
        chk("R1 err", int'(skid_err), 0);
    endtask

    task automatic t_run();
        feed(10, 0); step();
        chk("R2 vld", int'(out_vld), 1);
        chk("R2 seq", int'(out_seq), 10);
        chk("R2 skid", int'(out_skid), 0);
        chk("R2 state", int'(state_o), 1);
        rob_empty = 1'b0; feed(11, 0); step();
        chk("R2 seq busy rob", int'(out_seq), 11);
        rob_empty = 1'b1; quiet(); step();
        chk("R2 idle cycle", int'(out_vld), 0);
    endtask

    task automatic t_block();
        stall_req = 1'b1; feed(20, 0); step();
        chk("R3 state", int'(state_o), 2);
        chk("R3 blk", int'(blk_dec), 1);
        chk("R3 no issue", int'(out_vld), 0);
        feed(21, 0); step();
        chk("R3 no reblock", int'(blk_dec), 0);
        stall_req = 1'b0; res_full = 1'b1; feed(22, 0); step();
        chk("R3 res_full held", int'(state_o), 2);
        quiet(); step();
        chk("R4 unblocking", int'(state_o), 3);
        chk("R4 no unblk yet", int'(unblk_dec), 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 skid seq", int'(out_seq), 20 + i);
            chk("R4 skid src", int'(out_skid & out_vld), 1);
        end
        step();
        chk("R4 back to run", int'(state_o), 1);
        chk("R4 unblk", int'(unblk_dec), 1);
        chk("R4 nothing issued", int'(out_vld), 0);
    endtask

    task automatic t_squash_prio();
        stall_req = 1'b1; squash_vld = 1'b1; squash_seq = 16'd5; feed(25, 0); step();
        chk("R5 squashing", int'(state_o), 4);
        chk("R5 no blk", int'(blk_dec), 0);
        chk("R5 no issue", int'(out_vld), 0);
        quiet(); step();
        chk("R8 to run", int'(state_o), 1);
        chk("R8 no unblk", int'(unblk_dec), 0);
    endtask

    task automatic t_squash_blocked();
        stall_req = 1'b1; feed(30, 0); step();
        chk("R3 blk", int'(blk_dec), 1);
        quiet(); squash_vld = 1'b1; squash_seq = 16'd29; step();
        chk("R6 unblk", int'(unblk_dec), 1);
        chk("R6 squashing", int'(state_o), 4);
        quiet(); step();
        chk("R6 run", int'(state_o), 1);
        stall_req = 1'b1; step();
        quiet(); step();
        chk("R5 unblocking", int'(state_o), 3);
        step();
        chk("R5 skid flushed", int'(out_vld), 0);
        chk("R5 run after empty", int'(state_o), 1);
    endtask

    task automatic t_serialize();
        rob_empty = 1'b0; feed(40, 1); step();
        chk("R9 stall state", int'(state_o), 5);
        chk("R9 blk", int'(blk_dec), 1);
        chk("R9 held", int'(out_vld), 0);
        feed(41, 0); step();
        chk("R9 still held", int'(state_o), 5);
        quiet(); rob_empty = 1'b1; inflight = 6'd3; step();
        chk("R9 inflight holds", int'(state_o), 5);
        inflight = 6'd0; stall_req = 1'b1; step();
        chk("R9 stall holds", int'(state_o), 5);
        quiet(); step();
        chk("R9 unblocking", int'(state_o), 3);
        step();
        chk("R9 held first", int'(out_seq), 40);
        chk("R9 kind", int'(out_kind), 1);
        step();
        chk("R9 then queued", int'(out_seq), 41);
        step();
        chk("R9 unblk", int'(unblk_dec), 1);
    endtask

    task automatic t_squash_keep();
        rob_empty = 1'b0; feed(50, 1); step();
        quiet(); squash_vld = 1'b1; squash_seq = 16'd60; step();
        chk("R7 keep no unblk", int'(unblk_dec), 0);
        quiet(); step();
        chk("R7 resume stall", int'(state_o), 5);
        rob_empty = 1'b1; step();
        chk("R7 unblocking", int'(state_o), 3);
        step();
        chk("R7 held issued", int'(out_seq), 50);
        chk("R7 issued vld", int'(out_vld), 1);
        step();
        chk("R7 unblk", int'(unblk_dec), 1);
    endtask

    task automatic t_squash_drop();
        rob_empty = 1'b0; feed(70, 1); step();
        quiet(); squash_vld = 1'b1; squash_seq = 16'd65; step();
        chk("R7 drop unblk", int'(unblk_dec), 1);
        quiet(); step();
        chk("R7 drop run", int'(state_o), 1);
        rob_empty = 1'b1; step();
        chk("R7 dropped gone", int'(out_vld), 0);
    endtask

    task automatic t_squash_stall();
        squash_vld = 1'b1; squash_seq = 16'd0; step();
        quiet(); stall_req = 1'b1; step();
        chk("R8 stay squash", int'(state_o), 4);
        chk("R8 blk once", int'(blk_dec), 1);
        step();
        chk("R8 no second blk", int'(blk_dec), 0);
        quiet(); step();
        chk("R8 unblocking", int'(state_o), 3);
        step();
        chk("R8 run unblk", int'(unblk_dec), 1);
    endtask

    task automatic t_ser_after();
        rob_empty = 1'b0; feed(80, 2); step();
        chk("R10 after issued", int'(out_kind), 2);
        feed(81, 0); step();
        chk("R10 next held", int'(state_o), 5);
        chk("R10 blk", int'(blk_dec), 1);
        quiet(); rob_empty = 1'b1; step();
        step();
        chk("R10 marked seq", int'(out_seq), 81);
        chk("R10 marked kind", int'(out_kind), 1);
        step();
        chk("R10 unblk", int'(unblk_dec), 1);
        feed(90, 2); step();
        feed(91, 0); step();
        chk("R10 drained seq", int'(out_seq), 91);
        chk("R10 drained kind", int'(out_kind), 0);
        quiet(); step();
    endtask

    task automatic t_full_skid();
        stall_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            feed(100 + i, 0); step();
        end
        chk("R11 no err at depth", int'(skid_err), 0);
        quiet(); step();
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R11 order", int'(out_seq), 100 + i);
        end
        step();
        chk("R11 run", int'(state_o), 1);
        chk("R11 err clear", int'(skid_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run();
        t_block();
        t_squash_prio();
        t_squash_blocked();
        t_serialize();
        t_squash_keep();
        t_squash_drop();
        t_squash_stall();
        t_ser_after();
        t_full_skid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule